// File: doc/BRIEF.md
# Reconfigurable Selector-Network ALU

This block is an n-bit ALU built from identical one-bit slices. Each slice is a tiny two-layer network whose three "neurons" are plain selectors over configuration bits: two hidden selectors read the operand pair, and one output selector reads the pair of hidden results. A coefficient decoder holds small signed integer weights and biases for each operation. For each operation it fires a hard-limit threshold, whose output is the inverted sign bit of bias plus weighted inputs, to produce the selector tables. Changing the operation code therefore only changes table contents, never the datapath.

In logic mode the output selector combines the hidden results into one of seven two-input functions. In arithmetic mode the hidden selectors widen to take the incoming carry or borrow as a third index bit. They then act directly as full-adder or full-subtractor sum/difference and carry/borrow, and the output selector is bypassed. Slices ripple the carry or borrow from bit 0 upward. Results and the final carry/borrow are registered once.

Top module: `alu_recon`

## Requirements
- R1: Opcode 0 gives A AND B and opcode 1 gives NOT(A AND B), bitwise over all WIDTH bits.
- R2: Opcode 2 gives A OR B and opcode 3 gives NOT(A OR B), bitwise.
- R3: Opcode 4 gives A XOR B and opcode 5 gives NOT(A XOR B), bitwise.
- R4: Opcode 6 gives NOT A, and the value on B has no effect on the result.
- R5: Opcode 8 gives the low WIDTH bits of A+B on the result and the carry out of the top bit on the status output.
- R6: Opcode 9 gives the low WIDTH bits of A-B on the result, and the status output is 1 exactly when A < B unsigned.
- R7: Opcodes 7 and 10 to 15 drive the result and the status output to zero.
- R8: For every logic opcode (0 to 6) the status output is 0.
- R9: While rst_n is low, the result and the status output are 0, whatever the other inputs are.
- R10: Outputs change one clock after the inputs are sampled, and hold their previous values until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| res_o | output | WIDTH | Registered result |
| co_o | output | 1 | Registered carry (add) or borrow (subtract) out |

## Verification
A wrong entry in a decoded selector table shows up at the result port on the very next clock. It appears for the one operand combination (and carry-in, in arithmetic mode) that indexes that entry, which is why operand pairs are swept exhaustively on a one-bit instance. A broken ripple link only shows when a carry or borrow must cross that slice, so the 8-bit sweep uses all-ones plus one, zero minus one and alternating patterns. A leak of the chain into logic mode shows as a nonzero status bit in the cycle after any logic opcode.

// File: rtl/alu_cell_pkg.sv
package alu_cell_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_NAND = 4'd1,
    OP_OR   = 4'd2,
    OP_NOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_XNOR = 4'd5,
    OP_NOT  = 4'd6,
    OP_ADD  = 4'd8,
    OP_SUB  = 4'd9
  } alu_op_e;

  localparam int COEF_W = 3;            // signed range -4..3 covers -3..3
  localparam int ACC_W  = COEF_W + 2;   // holds bias + two weights
  localparam int HID_IDX_W = 3;         // {a, b, carry}
  localparam int OUT_IDX_W = 2;         // {f1, f2}

  typedef struct packed {
    logic signed [COEF_W-1:0] bias;
    logic signed [COEF_W-1:0] w1;
    logic signed [COEF_W-1:0] w2;
  } neuron_coef_t;

  typedef struct packed {
    neuron_coef_t hid1;
    neuron_coef_t hid2;
    neuron_coef_t outn;
  } op_coef_t;

  typedef struct packed {
    logic [2**HID_IDX_W-1:0] tab1;
    logic [2**HID_IDX_W-1:0] tab2;
    logic [2**OUT_IDX_W-1:0] tab3;
    logic                    arith;
  } slice_cfg_t;

  function automatic neuron_coef_t mk_coef(input int bias, input int w1, input int w2);
    neuron_coef_t c;
    c.bias = COEF_W'(bias);
    c.w1   = COEF_W'(w1);
    c.w2   = COEF_W'(w2);
    return c;
  endfunction

  // Hard-limit neuron: 1 when bias + w1*x1 + w2*x2 >= 0, i.e. inverted sign bit.
  function automatic logic neuron_fire(input neuron_coef_t c, input logic x1, input logic x2);
    logic signed [ACC_W-1:0] acc;
    acc = ACC_W'(c.bias);
    if (x1) acc = acc + ACC_W'(c.w1);
    if (x2) acc = acc + ACC_W'(c.w2);
    return ~acc[ACC_W-1];
  endfunction

  // Integer coefficients per logic operation. Hidden layer defaults: OR and NAND.
  function automatic op_coef_t op_coef(input alu_op_e op);
    op_coef_t c;
    c.hid1 = mk_coef(-1, 1, 1);
    c.hid2 = mk_coef( 1,-1,-1);
    c.outn = mk_coef(-1, 0, 0);
    case (op)
      OP_AND:  c.outn = mk_coef(-1, 1,-1);
      OP_NAND: c.outn = mk_coef(-1, 0, 1);
      OP_OR:   c.outn = mk_coef(-1, 1, 0);
      OP_NOR:  c.outn = mk_coef( 0,-1, 0);
      OP_XOR:  c.outn = mk_coef(-2, 1, 1);
      OP_XNOR: c.outn = mk_coef( 1,-1,-1);
      OP_NOT: begin
        c.hid1 = mk_coef( 0,-1, 0);
        c.outn = mk_coef(-1, 1, 0);
      end
      default: c.outn = mk_coef(-1, 0, 0);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_coef_dec.sv
module alu_coef_dec
  import alu_cell_pkg::*;
(
  input  logic [3:0]  op_i,
  output slice_cfg_t  cfg_o
);

  localparam int HID_N = 2**HID_IDX_W;
  localparam int OUT_N = 2**OUT_IDX_W;

  alu_op_e  op;
  op_coef_t coef;

  assign op   = alu_op_e'(op_i);
  assign coef = op_coef(op);

  always_comb begin
    cfg_o = '0;
    case (op)
      OP_AND, OP_NAND, OP_OR, OP_NOR, OP_XOR, OP_XNOR, OP_NOT: begin
        for (int i = 0; i < HID_N; i++) begin
          // index bits {a, b, carry}; carry bit replicated so it has no effect
          cfg_o.tab1[i] = neuron_fire(coef.hid1, i[2], i[1]);
          cfg_o.tab2[i] = neuron_fire(coef.hid2, i[2], i[1]);
        end
        for (int k = 0; k < OUT_N; k++) begin
          cfg_o.tab3[k] = neuron_fire(coef.outn, k[1], k[0]);
        end
      end
      OP_ADD, OP_SUB: begin
        cfg_o.arith = 1'b1;
        for (int i = 0; i < HID_N; i++) begin
          cfg_o.tab1[i] = i[2] ^ i[1] ^ i[0];
          if (op == OP_ADD)
            cfg_o.tab2[i] = (i[2] & i[1]) | (i[2] & i[0]) | (i[1] & i[0]);
          else
            cfg_o.tab2[i] = (~i[2] & i[1]) | (~i[2] & i[0]) | (i[1] & i[0]);
        end
      end
      default: cfg_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_neuron_sel.sv
module alu_neuron_sel #(
  parameter int IDX_W = 2
) (
  input  logic [2**IDX_W-1:0] tab_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic                y_o
);

  assign y_o = tab_i[idx_i];

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_cell_pkg::*;
(
  input  slice_cfg_t cfg_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       ci_i,
  output logic       r_o,
  output logic       co_o
);

  logic f1, f2, y;

  alu_neuron_sel #(.IDX_W(HID_IDX_W)) u_hid1 (
    .tab_i (cfg_i.tab1),
    .idx_i ({a_i, b_i, ci_i}),
    .y_o   (f1)
  );

  alu_neuron_sel #(.IDX_W(HID_IDX_W)) u_hid2 (
    .tab_i (cfg_i.tab2),
    .idx_i ({a_i, b_i, ci_i}),
    .y_o   (f2)
  );

  alu_neuron_sel #(.IDX_W(OUT_IDX_W)) u_outn (
    .tab_i (cfg_i.tab3),
    .idx_i ({f1, f2}),
    .y_o   (y)
  );

  assign r_o  = cfg_i.arith ? f1 : y;
  assign co_o = cfg_i.arith ? f2 : 1'b0;

endmodule

// File: rtl/alu_recon.sv
module alu_recon
  import alu_cell_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             co_o
);

  localparam int SYNC_STAGES = 2;

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  slice_cfg_t       cfg;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] res_d;
  logic             co_d;

  alu_coef_dec u_dec (
    .op_i  (op_i),
    .cfg_o (cfg)
  );

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    alu_bit_slice u_slice (
      .cfg_i (cfg),
      .a_i   (a_i[g]),
      .b_i   (b_i[g]),
      .ci_i  (chain[g]),
      .r_o   (res_d[g]),
      .co_o  (chain[g+1])
    );
  end

  assign co_d = chain[WIDTH];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_o <= '0;
      co_o  <= 1'b0;
    end else begin
      res_o <= res_d;
      co_o  <= co_d;
    end
  end

  p_add_sum_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_i == OP_ADD) |=> ({co_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  p_sub_borrow_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_i == OP_SUB) |=> (res_o == WIDTH'($past(a_i) - $past(b_i)) && co_o == ($past(a_i) < $past(b_i))));

  p_not_ignores_b_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_i == OP_NOT) |=> (res_o == ~$past(a_i)));

  p_invalid_zero_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg.tab1 == '0 && cfg.tab3 == '0 && !cfg.arith && op_i != OP_NOR && op_i != OP_XNOR)
      |=> (res_o == '0 && !co_o));

  p_logic_no_status_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cfg.arith) |=> !co_o);

endmodule

// File: tb/test_alu_recon.sv
module test_alu_recon;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op8, op1;
  logic [7:0] a8, b8, r8;
  logic [0:0] a1, b1, r1;
  logic       co8, co1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  alu_recon #(.WIDTH(8)) i_alu_recon (
    .clk (clk), .rst_n (rst_n), .op_i (op8), .a_i (a8), .b_i (b8),
    .res_o (r8), .co_o (co8)
  );

  alu_recon #(.WIDTH(1)) i_alu_recon_w1 (
    .clk (clk), .rst_n (rst_n), .op_i (op1), .a_i (a1), .b_i (b1),
    .res_o (r1), .co_o (co1)
  );

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4, 4'd5: return "R3";
      4'd6:       return "R4";
      4'd8:       return "R5";
      4'd9:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  function automatic string co_tag(input logic [3:0] op);
    if (op <= 4'd6) return "R8";
    return res_tag(op);
  endfunction

  task automatic ref_alu(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input int w, output logic [7:0] r, output logic c);
    logic [8:0] s;
    logic [7:0] mask;
    mask = 8'((9'd1 << w) - 9'd1);
    c = 1'b0;
    case (op)
      4'd0: r = a & b;
      4'd1: r = ~(a & b);
      4'd2: r = a | b;
      4'd3: r = ~(a | b);
      4'd4: r = a ^ b;
      4'd5: r = ~(a ^ b);
      4'd6: r = ~a;
      4'd8: begin s = {1'b0, a & mask} + {1'b0, b & mask}; r = s[7:0]; c = s[w]; end
      4'd9: begin r = (a & mask) - (b & mask); c = ((a & mask) < (b & mask)); end
      default: r = 8'h00;
    endcase
    r = r & mask;
  endtask

  task automatic check(input string tag, input logic [7:0] got_r, input logic [7:0] exp_r,
                       input logic got_c, input logic exp_c, input string ctag);
    checks++;
    if (got_r !== exp_r) begin
      errors++;
      $display("FAIL %s result: got %h expected %h", tag, got_r, exp_r);
    end
    checks++;
    if (got_c !== exp_c) begin
      errors++;
      $display("FAIL %s status: got %b expected %b", ctag, got_c, exp_c);
    end
  endtask

  task automatic run8(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] er;
    logic ec;
    @(negedge clk);
    op8 = op; a8 = a; b8 = b;
    @(negedge clk);
    ref_alu(op, a, b, 8, er, ec);
    check(res_tag(op), r8, er, co8, ec, co_tag(op));
  endtask

  task automatic run1(input logic [3:0] op, input logic a, input logic b);
    logic [7:0] er;
    logic ec;
    @(negedge clk);
    op1 = op; a1 = a; b1 = b;
    @(negedge clk);
    ref_alu(op, {7'd0, a}, {7'd0, b}, 1, er, ec);
    check(res_tag(op), {7'd0, r1}, er, co1, ec, co_tag(op));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op8 = 4'd8; a8 = 8'hff; b8 = 8'h01;
    op1 = 4'd8; a1 = 1'b1; b1 = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero during reset despite live inputs
    check("R9", r8, 8'h00, co8, 1'b0, "R9");
    check("R9", {7'd0, r1}, 8'h00, co1, 1'b0, "R9");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // one-bit instance: every opcode against every operand pair
    for (int op = 0; op < 16; op++)
      for (int p = 0; p < 4; p++)
        run1(4'(op), p[1], p[0]);

    // eight-bit instance: corner and random operands for every opcode
    for (int op = 0; op < 16; op++) begin
      run8(4'(op), 8'h00, 8'h00);
      run8(4'(op), 8'hff, 8'hff);
      run8(4'(op), 8'hff, 8'h01);
      run8(4'(op), 8'h00, 8'h01);
      run8(4'(op), 8'h80, 8'h80);
      run8(4'(op), 8'h55, 8'haa);
      for (int k = 0; k < 20; k++)
        run8(4'(op), 8'($urandom), 8'($urandom));
    end

    // R4: same A, different B values give identical result
    run8(4'd6, 8'h3c, 8'h00);
    run8(4'd6, 8'h3c, 8'hff);
    run8(4'd6, 8'h3c, 8'h5a);

    // R10: one clock of latency, outputs hold until the edge
    run8(4'd8, 8'hff, 8'h01);
    @(negedge clk);
    op8 = 4'd0; a8 = 8'h0f; b8 = 8'hff;
    #1;
    check("R10", r8, 8'h00, co8, 1'b1, "R10");
    @(negedge clk);
    check("R10", r8, 8'h0f, co8, 1'b0, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule